// File: doc/BRIEF.md
# SIMD Partitioned Integer Multiplier

This block multiplies two 64-bit operands that can be cut at runtime into independent lanes of 8, 16, 32 or 64 bits. A cut can be placed at any of the seven byte boundaries inside the word. Each lane chooses its own operation. A low-half lane returns the lower lane-width bits of its product. A high-half lane returns the upper lane-width bits, and its two operands are taken as signed or unsigned independently of each other. One operation word is presented per clock and the results follow at a fixed latency.

The block has two outputs. The first is a 64-bit packed result that holds one lane-width result per lane. The second is a 128-bit wide product that holds every lane's full double-width product. A lane's flags come from the lowest byte of that lane. The data path has two configurable groups of registers: one between the product array and the lane result selection, and one at the outputs. The per-byte lane controls travel in step with the data through these registers.

Legal cut patterns form naturally aligned power-of-two lanes. Any other pattern gives a fixed, repeatable result: each byte joins the largest aligned group that contains no cut.

Top module: `simd_mul`

## Requirements
- R1: `split[k]` = 1 places a lane boundary between byte k and byte k+1 (byte 0 is bits 7:0). With an aligned pattern, each lane is exactly the run of bytes between consecutive boundaries. The patterns covered are: all cleared (one 64-bit lane), all set (eight 8-bit lanes), every 16-bit or 32-bit split, and mixed splits.
- R2: An operand of a lane is sign-extended when the lane treats it as signed and its top bit is 1. Otherwise it is zero-extended.
- R3: A lane with `lane_hi` = 0 treats both operands as signed whatever its signed flags say. Its packed result is therefore the same for every flag setting.
- R4: The full product of a lane that starts at bit S and is W bits wide is truncated to 2W bits and placed in `wide_product` at bit 2S.
- R5: In `product`, a lane with `lane_hi` = 1 returns bits 2W-1:W of its full product, and a lane with `lane_hi` = 0 returns bits W-1:0. Either result is placed at bit S.
- R6: Results appear MID_LVL+OUT_LVL rising edges after their operands are applied, which is 2 with the default parameters. A new operand set is accepted on every clock.
- R7: While `rst_n` is low, `product` and `wide_product` read zero.
- R8: The hi, a-signed and b-signed flags of a lane are taken from its lowest byte. The flags of the other bytes in that lane have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 64 | First operand, packed lanes |
| opb | input | 64 | Second operand, packed lanes |
| split | input | 7 | Bit k cuts between byte k and byte k+1 |
| lane_hi | input | 8 | Per byte: 1 selects the high half |
| lane_a_signed | input | 8 | Per byte: opa treated as signed for high half |
| lane_b_signed | input | 8 | Per byte: opb treated as signed for high half |
| product | output | 64 | Packed lane results |
| wide_product | output | 128 | Full double-width lane products |

## Verification
The hardest case to reach is a mixed split in which a wide lane's inner bytes carry flags that contradict the flags of its lowest byte. If the wrong byte's flag were used, the result would change only when the operand's top bit happens to be set. The stimulus therefore randomises the flags of every byte independently and uses operands whose lane top bits are set, such as all ones and 0x80 in every byte. Each of these words is applied under every aligned and mixed split pattern. The reference model reads flags only at lane starts, so a design that reads the wrong byte produces a mismatch.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int LG_W = 3;

    // log2 of a lane's size in bytes
    typedef logic [LG_W-1:0] lane_lg_t;

    // first byte of the aligned lane of 2**lg bytes holding byte k
    function automatic int lane_start(input int k, input lane_lg_t lg);
        return (k >> lg) << lg;
    endfunction

endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
    import simd_mul_pkg::*;
#(
    parameter int N_BYTES = 8
) (
    input  logic [N_BYTES-2:0]             split,
    input  logic [N_BYTES-1:0]             lane_hi,
    input  logic [N_BYTES-1:0]             lane_a_signed,
    input  logic [N_BYTES-1:0]             lane_b_signed,
    output lane_lg_t [N_BYTES-1:0]         lg_vec,
    output logic [N_BYTES-1:0]             hi_res,
    output logic [N_BYTES-1:0]             a_se,
    output logic [N_BYTES-1:0]             b_se
);
    localparam int LOG_N = $clog2(N_BYTES);
    localparam int IDX_W = (LOG_N < 1) ? 1 : LOG_N;
    localparam int SPW   = N_BYTES - 1;

    // a low-half lane multiplies as signed; the low bits do not differ
    assign a_se = lane_a_signed | ~lane_hi;
    assign b_se = lane_b_signed | ~lane_hi;

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        lane_lg_t pick [LOG_N+2];
        assign pick[0] = '0;
        for (genvar L = 0; L <= LOG_N; L++) begin : g_lvl
            localparam int S = (k >> L) << L;
            localparam int G = 1 << L;
            localparam logic [SPW-1:0] INNER = SPW'(((64'd1 << (G - 1)) - 64'd1) << S);
            logic fits;
            assign fits = ~|(split & INNER);
            assign pick[L+1] = fits ? lane_lg_t'(L) : pick[L];
        end
        assign lg_vec[k] = pick[LOG_N+1];
        assign hi_res[k] = lane_hi[IDX_W'(lane_start(k, pick[LOG_N+1]))];
    end

    for (genvar k = 0; k < N_BYTES - 1; k++) begin : g_chk
        always_comb begin
            if (split[k]) begin
                a_r1_cut_starts_lane: assert (lane_start(k + 1, lg_vec[k+1]) == k + 1)
                    else $error("R1: byte %0d after a cut is not a lane start", k + 1);
            end
        end
    end

endmodule

// File: rtl/simd_mul_products.sv
module simd_mul_products
    import simd_mul_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 8
) (
    input  logic [BYTE_W*N_BYTES-1:0]   opa,
    input  logic [BYTE_W*N_BYTES-1:0]   opb,
    input  logic [N_BYTES-1:0]          a_se,
    input  logic [N_BYTES-1:0]          b_se,
    input  lane_lg_t [N_BYTES-1:0]      lg_vec,
    output logic [2*BYTE_W*N_BYTES-1:0] wide
);
    localparam int DW    = BYTE_W * N_BYTES;
    localparam int CW    = 2 * BYTE_W;
    localparam int LOG_N = $clog2(N_BYTES);

    logic [2*DW-1:0] acc [LOG_N+2];
    assign acc[0] = '0;

    // one bank of lane products per lane size; each double-byte chunk
    // of the result keeps the bank matching its own lane size
    for (genvar L = 0; L <= LOG_N; L++) begin : g_lvl
        localparam int W     = BYTE_W << L;
        localparam int PW    = 2 * W;
        localparam int LANES = N_BYTES >> L;
        logic [2*DW-1:0] lvl_p;
        logic [2*DW-1:0] keep;

        for (genvar j = 0; j < LANES; j++) begin : g_lane
            localparam int S = j * W;
            logic signed [W:0]    xa;
            logic signed [W:0]    xb;
            logic signed [PW-1:0] p;
            assign xa = {a_se[j << L] & opa[S+W-1], opa[S +: W]};
            assign xb = {b_se[j << L] & opb[S+W-1], opb[S +: W]};
            assign p  = PW'(xa) * PW'(xb);
            assign lvl_p[2*S +: PW] = p;
        end

        for (genvar m = 0; m < N_BYTES; m++) begin : g_keep
            assign keep[m*CW +: CW] = {CW{lg_vec[m] == lane_lg_t'(L)}};
        end

        assign acc[L+1] = acc[L] | (lvl_p & keep);
    end

    assign wide = acc[LOG_N+1];

    logic [N_BYTES-1:0] byte_lane;
    logic [N_BYTES-1:0] whole_lane;

    for (genvar m = 0; m < N_BYTES; m++) begin : g_chk
        logic [BYTE_W-1:0] ab;
        logic [BYTE_W-1:0] bb;
        assign ab = opa[m*BYTE_W +: BYTE_W];
        assign bb = opb[m*BYTE_W +: BYTE_W];
        assign byte_lane[m]  = (lg_vec[m] == '0);
        assign whole_lane[m] = (lg_vec[m] == lane_lg_t'(LOG_N));

        always_comb begin
            if (&byte_lane) begin
                if (ab == '0) begin
                    a_r4_zero_operand_zero_chunk: assert (wide[m*CW +: CW] == '0)
                        else $error("R4: chunk %0d non-zero for a zero operand", m);
                end
                if (bb == BYTE_W'(1)) begin
                    a_r2_extend_by_one: assert (wide[m*CW +: CW] ==
                                                {{BYTE_W{a_se[m] & ab[BYTE_W-1]}}, ab})
                        else $error("R2: chunk %0d wrong extension", m);
                end
            end
        end
    end

    always_comb begin
        if (&whole_lane) begin
            a_r3_low_bits_sign_free: assert (wide[DW-1:0] == opa * opb)
                else $error("R3: low bits of whole-word product differ from unsigned");
        end
    end

endmodule

// File: rtl/simd_mul_assemble.sv
module simd_mul_assemble
    import simd_mul_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 8
) (
    input  logic [2*BYTE_W*N_BYTES-1:0] wide,
    input  logic [N_BYTES-1:0]          hi_res,
    input  lane_lg_t [N_BYTES-1:0]      lg_vec,
    output logic [BYTE_W*N_BYTES-1:0]   product
);
    localparam int IXW = $clog2(2 * N_BYTES);

    logic [BYTE_W-1:0] wide_b [2*N_BYTES];

    for (genvar i = 0; i < 2 * N_BYTES; i++) begin : g_split
        assign wide_b[i] = wide[i*BYTE_W +: BYTE_W];
    end

    // byte k at offset r in a lane starting at s of g bytes reads
    // wide byte 2s+r (low half) or 2s+g+r (high half)
    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        logic [IXW-1:0] idx;
        always_comb begin
            int g_i;
            int s_i;
            g_i = 1 << lg_vec[k];
            s_i = lane_start(k, lg_vec[k]);
            idx = hi_res[k] ? IXW'(k + s_i + g_i) : IXW'(k + s_i);
        end
        assign product[k*BYTE_W +: BYTE_W] = wide_b[idx];
    end

endmodule

// File: rtl/simd_mul_delay.sv
module simd_mul_delay #(
    parameter int W      = 1,
    parameter int LEVELS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (LEVELS == 0) begin : g_pass
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] st [LEVELS];
        for (genvar i = 0; i < LEVELS; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st[i] <= '0;
                end else begin
                    st[i] <= (i == 0) ? d : st[(i == 0) ? 0 : i - 1];
                end
            end
        end
        assign q = st[LEVELS-1];
    end

endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_mul_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 8,
    parameter int MID_LVL = 1,
    parameter int OUT_LVL = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BYTE_W*N_BYTES-1:0]   opa,
    input  logic [BYTE_W*N_BYTES-1:0]   opb,
    input  logic [N_BYTES-2:0]          split,
    input  logic [N_BYTES-1:0]          lane_hi,
    input  logic [N_BYTES-1:0]          lane_a_signed,
    input  logic [N_BYTES-1:0]          lane_b_signed,
    output logic [BYTE_W*N_BYTES-1:0]   product,
    output logic [2*BYTE_W*N_BYTES-1:0] wide_product
);
    localparam int DW    = BYTE_W * N_BYTES;
    localparam int CTL_W = N_BYTES * (1 + LG_W);
    localparam int MID_W = 2 * DW + CTL_W;
    localparam int OUT_W = 3 * DW;

    lane_lg_t [N_BYTES-1:0] lg_d;
    lane_lg_t [N_BYTES-1:0] lg_m;
    logic [N_BYTES-1:0]     hi_d;
    logic [N_BYTES-1:0]     hi_m;
    logic [N_BYTES-1:0]     a_se;
    logic [N_BYTES-1:0]     b_se;
    logic [2*DW-1:0]        wide_d;
    logic [2*DW-1:0]        wide_m;
    logic [DW-1:0]          prod_m;
    logic [MID_W-1:0]       mid_q;
    logic [OUT_W-1:0]       out_q;

    simd_mul_decode #(.N_BYTES(N_BYTES)) i_decode (
        .split         (split),
        .lane_hi       (lane_hi),
        .lane_a_signed (lane_a_signed),
        .lane_b_signed (lane_b_signed),
        .lg_vec        (lg_d),
        .hi_res        (hi_d),
        .a_se          (a_se),
        .b_se          (b_se)
    );

    simd_mul_products #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) i_products (
        .opa    (opa),
        .opb    (opb),
        .a_se   (a_se),
        .b_se   (b_se),
        .lg_vec (lg_d),
        .wide   (wide_d)
    );

    // lane controls travel with the products
    simd_mul_delay #(.W(MID_W), .LEVELS(MID_LVL)) i_mid (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wide_d, hi_d, lg_d}),
        .q     (mid_q)
    );

    assign {wide_m, hi_m, lg_m} = mid_q;

    simd_mul_assemble #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) i_assemble (
        .wide    (wide_m),
        .hi_res  (hi_m),
        .lg_vec  (lg_m),
        .product (prod_m)
    );

    simd_mul_delay #(.W(OUT_W), .LEVELS(OUT_LVL)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({prod_m, wide_m}),
        .q     (out_q)
    );

    assign {product, wide_product} = out_q;

endmodule

// File: tb/test_simd_mul.sv
module test_simd_mul;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  opa = '0;
    logic [63:0]  opb = '0;
    logic [6:0]   split = '0;
    logic [7:0]   lane_hi = '0;
    logic [7:0]   lane_a_signed = '0;
    logic [7:0]   lane_b_signed = '0;
    logic [63:0]  product;
    logic [127:0] wide_product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0]  q_res [$];
    logic [127:0] q_wide [$];
    string        q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_mul #(.BYTE_W(8), .N_BYTES(8), .MID_LVL(1), .OUT_LVL(1)) i_simd_mul (
        .clk           (clk),
        .rst_n         (rst_n),
        .opa           (opa),
        .opb           (opb),
        .split         (split),
        .lane_hi       (lane_hi),
        .lane_a_signed (lane_a_signed),
        .lane_b_signed (lane_b_signed),
        .product       (product),
        .wide_product  (wide_product)
    );

    // behavioural reference: walk lanes from cut to cut, flags from lane start
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [6:0] sp, input logic [7:0] hi,
                                  input logic [7:0] asg, input logic [7:0] bsg,
                                  output logic [63:0] r, output logic [127:0] w);
        int s = 0;
        r = '0;
        w = '0;
        while (s < 8) begin
            int e = s;
            int nb;
            logic [127:0] mask, m2, pa, pb, p, sel;
            while (e < 7 && !sp[e]) e++;
            nb   = 8 * (e - s + 1);
            mask = {128{1'b1}} >> (128 - nb);
            m2   = {128{1'b1}} >> (128 - 2 * nb);
            pa   = ({64'b0, a} >> (8 * s)) & mask;
            pb   = ({64'b0, b} >> (8 * s)) & mask;
            if ((asg[s] || !hi[s]) && pa[nb-1]) pa = pa | ~mask;
            if ((bsg[s] || !hi[s]) && pb[nb-1]) pb = pb | ~mask;
            p   = (pa * pb) & m2;
            w   = w | (p << (16 * s));
            sel = hi[s] ? ((p >> nb) & mask) : (p & mask);
            r   = r | 64'(sel << (8 * s));
            s   = e + 1;
        end
    endfunction

    task automatic check_front(input bit drain);
        if (q_res.size() == LAT || (drain && q_res.size() > 0)) begin
            logic [63:0]  er = q_res.pop_front();
            logic [127:0] ew = q_wide.pop_front();
            string        t  = q_tag.pop_front();
            checks++;
            if (product !== er) begin
                errors++;
                $display("FAIL %s packed (R5): actual %h expected %h", t, product, er);
            end
            checks++;
            if (wide_product !== ew) begin
                errors++;
                $display("FAIL %s wide (R4): actual %h expected %h", t, wide_product, ew);
            end
        end
    endtask

    task automatic step(input logic [63:0] a, input logic [63:0] b,
                        input logic [6:0] sp, input logic [7:0] hi,
                        input logic [7:0] asg, input logic [7:0] bsg,
                        input string tag);
        logic [63:0]  r;
        logic [127:0] w;
        @(negedge clk);
        check_front(1'b0);
        opa = a; opb = b; split = sp;
        lane_hi = hi; lane_a_signed = asg; lane_b_signed = bsg;
        model(a, b, sp, hi, asg, bsg, r, w);
        q_res.push_back(r);
        q_wide.push_back(w);
        q_tag.push_back(tag);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    logic [6:0]  pats [6];
    logic [63:0] corner [5];

    initial begin
        pats[0] = 7'b0000000;   // one 64-bit lane
        pats[1] = 7'b1111111;   // eight 8-bit lanes
        pats[2] = 7'b0101010;   // four 16-bit lanes
        pats[3] = 7'b0001000;   // two 32-bit lanes
        pats[4] = 7'b1101000;   // 32 | 16 | 8 | 8 from byte 0 up
        pats[5] = 7'b0001011;   // 8 | 8 | 16 | 32 from byte 0 up
        corner[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[1] = 64'h8080_8080_8080_8080;
        corner[2] = 64'h8000_8000_8000_8000;
        corner[3] = 64'h7F7F_7F7F_7F7F_7F7F;
        corner[4] = 64'h0123_4567_89AB_CDEF;

        // R7: outputs held at zero during reset, inputs busy
        opa = rnd64(); opb = rnd64(); split = 7'h55; lane_hi = 8'hA5;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (product !== '0 || wide_product !== '0) begin
                errors++;
                $display("FAIL R7 reset: actual %h/%h expected 0/0", product, wide_product);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every split pattern with random words and flags
        for (int p = 0; p < 6; p++)
            for (int n = 0; n < 10; n++)
                step(rnd64(), rnd64(), pats[p], 8'($urandom()), 8'($urandom()),
                     8'($urandom()), "R1");

        // R2: high half, every signedness pair, operands with top bits set
        for (int p = 0; p < 6; p++)
            for (int sa = 0; sa < 2; sa++)
                for (int sb = 0; sb < 2; sb++)
                    for (int c = 0; c < 5; c++)
                        step(corner[c], corner[(c + 1) % 5], pats[p], 8'hFF,
                             {8{sa[0]}}, {8{sb[0]}}, "R2");

        // R3: low half with every flag setting
        for (int p = 0; p < 6; p++)
            for (int f = 0; f < 4; f++)
                for (int c = 0; c < 5; c++)
                    step(corner[c], rnd64(), pats[p], 8'h00,
                         {8{f[0]}}, {8{f[1]}}, "R3");

        // R5: half selection mixed across lanes
        for (int p = 0; p < 6; p++)
            for (int n = 0; n < 8; n++)
                step(corner[n % 5], corner[(n + 2) % 5], pats[p],
                     8'($urandom()), 8'($urandom()), 8'($urandom()), "R5");

        // R8: inner-byte flags contradict the lane start's flags
        for (int p = 0; p < 6; p++)
            for (int n = 0; n < 8; n++) begin
                logic [7:0] base = (n % 2 == 0) ? 8'h00 : 8'hFF;
                step(corner[n % 2], corner[(n + 1) % 2], pats[p],
                     base ^ 8'hFE, base ^ 8'hFE, base ^ 8'hFE, "R8");
            end

        // R6: an isolated word among zero words arrives exactly LAT edges later
        for (int n = 0; n < 4; n++) begin
            step(corner[n], corner[4], pats[n], 8'h0F, 8'hF0, 8'h3C, "R6");
            step('0, '0, pats[n], 8'h00, 8'h00, 8'h00, "R6");
            step('0, '0, pats[n], 8'hFF, 8'hFF, 8'hFF, "R6");
        end

        repeat (LAT) begin
            @(negedge clk);
            check_front(1'b1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule